// File: doc/BRIEF.md
# Re-encoding Channel Error Monitor

This block runs next to a hard-decision Viterbi decoder and estimates how many channel bits were corrupted. It takes each decoded bit and re-encodes it with the rate 1/2, constraint length 3 convolutional code (generators 7 and 5 in octal). It then compares the two regenerated code bits with the pair of bits received from the channel. The received pair passes through a delay line whose depth matches the decoder latency, so that it lines up with the decoded bit. Received bits that the front end flagged as erased take no part in the comparison.

Mismatches are added up over a measurement window. The window length is counted in symbols and is loaded at run time from an AXI4-Stream configuration input. When a window closes, its error total appears on an AXI4-Stream status output. The total is held there until the consumer accepts it, and the next window starts counting at once.

Top module: `ber_monitor`

## Requirements
- R1: Each accepted symbol carries a decoded bit d. With a and b the previous two decoded bits, where a is the more recent, the code bits are c0 = d^a^b and c1 = d^b. c0 is compared with the delayed `rx_bits[0]` and c1 with the delayed `rx_bits[1]`, and every unequal pair adds one to the window total.
- R2: The received pair accepted with symbol k is compared with the decoded bit of symbol k+DLY. Only symbols with `sym_valid` high are counted.
- R3: A received bit whose `rx_erase` bit was 1 when it entered (bit i guards `rx_bits[i]`) adds nothing, whatever its value.
- R4: The window length is taken from `cfg_tdata` when `cfg_tvalid` and `cfg_tready` are both high. A value of 0 is treated as 1. After reset the length is DEF_LEN.
- R5: A newly accepted length applies from the next window onward. A length accepted in the same cycle as the closing symbol already applies to the window that follows it.
- R6: On the clock edge that accepts a window's last symbol, `st_tvalid` rises with that window's total on `st_tdata`. Both hold until `st_tready` is high. A later window that closes before acceptance replaces the held total.
- R7: The 16-bit window total saturates at 16'hFFFF and never wraps.
- R8: `cfg_tready` is low while `rst_n` is low and high from the first clock edge after `rst_n` goes high.
- R9: Reset clears the encoder history, the running total and the symbol count, and drops `st_tvalid`. The delay line is filled with erased entries, so the first DLY symbols after reset add no errors.
- R10: A cycle with `sym_valid` low changes neither the total, the window position nor the encoder history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | A symbol is presented this cycle |
| dec_bit | input | 1 | Decoded bit from the decoder |
| rx_bits | input | 2 | Received hard code bits |
| rx_erase | input | 2 | Erasure flag for each received bit |
| cfg_tvalid | input | 1 | Configuration stream valid |
| cfg_tready | output | 1 | Configuration stream ready |
| cfg_tdata | input | LEN_W | Window length in symbols |
| st_tvalid | output | 1 | Status stream valid |
| st_tready | input | 1 | Status stream ready |
| st_tdata | output | CNT_W | Error total of the last closed window |

## Verification
A window total is due on the outputs one clock edge after the closing symbol is presented. The bench drives every input on a falling edge and samples on the next falling edge, so each check reads the register that the single rising edge in between has written. A received pair is due at the comparator DLY accepted symbols after it enters. The bench's reference model tracks this in symbols rather than cycles, so idle cycles placed among the symbols do not shift the expected totals. A length change is checked across the boundary of two windows, and the held status is checked during several stalled cycles.

// File: rtl/ber_monitor.sv
module ber_monitor #(
  parameter int DLY     = 4,
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 16,
  parameter int DEF_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             dec_bit,
  input  logic [1:0]       rx_bits,
  input  logic [1:0]       rx_erase,
  input  logic             cfg_tvalid,
  output logic             cfg_tready,
  input  logic [LEN_W-1:0] cfg_tdata,
  output logic             st_tvalid,
  input  logic             st_tready,
  output logic [CNT_W-1:0] st_tdata
);

  localparam logic [LEN_W-1:0] DEF_L = LEN_W'(DEF_LEN);
  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

  logic [1:0]       enc_hist;
  logic [1:0]       dl_rx [DLY];
  logic [1:0]       dl_er [DLY];
  logic [LEN_W-1:0] len_cur, len_pend, sym_cnt;
  logic [CNT_W-1:0] err_acc;
  logic             rdy_q, stv_q;
  logic [CNT_W-1:0] std_q;

  wire       code0 = dec_bit ^ enc_hist[0] ^ enc_hist[1];
  wire       code1 = dec_bit ^ enc_hist[1];
  wire [1:0] miss  = ({code1, code0} ^ dl_rx[DLY-1]) & ~dl_er[DLY-1];

  wire [CNT_W:0] sym_err = (CNT_W+1)'(miss[0]) + (CNT_W+1)'(miss[1]);
  wire [CNT_W:0] acc_sum = {1'b0, err_acc} + sym_err;
  wire [CNT_W-1:0] acc_sat = acc_sum[CNT_W] ? {CNT_W{1'b1}} : acc_sum[CNT_W-1:0];

  wire             cfg_fire = cfg_tvalid & rdy_q;
  wire [LEN_W-1:0] cfg_len  = (cfg_tdata == '0) ? ONE_L : cfg_tdata;
  wire [LEN_W-1:0] next_len = cfg_fire ? cfg_len : len_pend;
  wire             win_close = sym_valid && (sym_cnt == len_cur - ONE_L);

  assign cfg_tready = rdy_q;
  assign st_tvalid  = stv_q;
  assign st_tdata   = std_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_hist <= '0;
      for (int i = 0; i < DLY; i++) begin
        dl_rx[i] <= '0;
        dl_er[i] <= 2'b11;
      end
      len_cur  <= DEF_L;
      len_pend <= DEF_L;
      sym_cnt  <= '0;
      err_acc  <= '0;
      rdy_q    <= 1'b0;
      stv_q    <= 1'b0;
      std_q    <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (cfg_fire) len_pend <= cfg_len;
      if (stv_q && st_tready) stv_q <= 1'b0;
      if (sym_valid) begin
        enc_hist <= {enc_hist[0], dec_bit};
        for (int i = DLY - 1; i > 0; i--) begin
          dl_rx[i] <= dl_rx[i-1];
          dl_er[i] <= dl_er[i-1];
        end
        dl_rx[0] <= rx_bits;
        dl_er[0] <= rx_erase;
        if (win_close) begin
          std_q   <= acc_sat;
          stv_q   <= 1'b1;
          err_acc <= '0;
          sym_cnt <= '0;
          len_cur <= next_len;
        end else begin
          err_acc <= acc_sat;
          sym_cnt <= sym_cnt + ONE_L;
        end
      end
    end
  end

  a_r8_ready_low_in_reset: assert property (@(posedge clk) !rst_n |=> !cfg_tready);
  a_r8_ready_high_after: assert property (@(posedge clk) rst_n |=> cfg_tready);
  a_r9_status_cleared: assert property (@(posedge clk) !rst_n |=> !st_tvalid);
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    st_tvalid && !st_tready |=> st_tvalid);
  a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    st_tvalid && !st_tready && !win_close |=> $stable(st_tdata));
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> err_acc >= $past(err_acc));
  a_r5_len_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !win_close |=> $stable(len_cur));
  a_r10_idle_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |=> $stable(err_acc) && $stable(sym_cnt) && $stable(enc_hist));

endmodule

// File: tb/ber_monitor_tb.sv
module ber_monitor_tb_top;
  localparam int CLK_NS = 10;
  localparam int D = 4;

  logic clk = 0, rst_n = 0, sym_valid = 0, dec_bit = 0;
  logic [1:0] rx_bits = 0, rx_erase = 0;
  logic cfg_tvalid = 0, cfg_tready, st_tvalid, st_tready = 1;
  logic [15:0] cfg_tdata = 0, st_tdata;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [1:0] m_sr;
  logic [1:0] m_rx [D];
  logic [1:0] m_er [D];
  int m_acc, m_cnt, m_len, m_pend;

  // entry: {valid, dec, rx1, rx0, er1, er0}
  localparam logic [5:0] VEC [20] = '{
    6'b1_1_10_00, 6'b1_0_01_00, 6'b1_1_11_00, 6'b0_1_11_00,
    6'b1_1_00_00, 6'b1_0_10_01, 6'b1_0_11_10, 6'b1_1_01_00,
    6'b1_1_11_00, 6'b0_0_00_00, 6'b1_0_00_00, 6'b1_1_10_00,
    6'b1_1_01_00, 6'b1_0_11_11, 6'b0_1_01_00, 6'b1_1_00_00,
    6'b1_0_10_00, 6'b1_1_11_01, 6'b0_0_10_00, 6'b1_0_01_00
  };

  ber_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .dec_bit(dec_bit),
    .rx_bits(rx_bits), .rx_erase(rx_erase), .cfg_tvalid(cfg_tvalid),
    .cfg_tready(cfg_tready), .cfg_tdata(cfg_tdata), .st_tvalid(st_tvalid),
    .st_tready(st_tready), .st_tdata(st_tdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_sr = 0; m_acc = 0; m_cnt = 0; m_len = 8; m_pend = 8;
    for (int i = 0; i < D; i++) begin m_rx[i] = 0; m_er[i] = 2'b11; end
  endtask

  task automatic cyc(input bit v, input bit d, input logic [1:0] rx, input logic [1:0] er,
                     input bit cv, input int cd, input string tag);
    bit close; int expv; bit c0, c1; int e;
    close = 0; expv = 0;
    sym_valid = v; dec_bit = d; rx_bits = rx; rx_erase = er;
    cfg_tvalid = cv; cfg_tdata = 16'(cd);
    if (cv) m_pend = (cd == 0) ? 1 : cd;
    if (v) begin
      c0 = d ^ m_sr[0] ^ m_sr[1];
      c1 = d ^ m_sr[1];
      e = ((!m_er[D-1][0] && c0 != m_rx[D-1][0]) ? 1 : 0)
        + ((!m_er[D-1][1] && c1 != m_rx[D-1][1]) ? 1 : 0);
      m_acc = (m_acc + e > 65535) ? 65535 : m_acc + e;
      m_sr = {m_sr[0], d};
      for (int i = D - 1; i > 0; i--) begin m_rx[i] = m_rx[i-1]; m_er[i] = m_er[i-1]; end
      m_rx[0] = rx; m_er[0] = er;
      m_cnt++;
      if (m_cnt == m_len) begin
        close = 1; expv = m_acc; m_acc = 0; m_cnt = 0; m_len = m_pend;
      end
    end
    @(negedge clk);
    sym_valid = 0; cfg_tvalid = 0;
    if (close) chk(st_tvalid && int'(st_tdata) == expv, tag, int'(st_tdata), expv);
    else if (st_tready) chk(!st_tvalid, tag, int'(st_tvalid), 0);
  endtask

  task automatic finish_window(input string tag);
    int n;
    n = m_len - m_cnt;
    for (int i = 0; i < n; i++) cyc(1, 0, 2'b00, 2'b11, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(cfg_tready == 0, "R8", int'(cfg_tready), 0);
    chk(st_tvalid == 0, "R9", int'(st_tvalid), 0);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk(cfg_tready == 1, "R8", int'(cfg_tready), 1);
  endtask

  initial begin
    logic [15:0] held;
    model_reset();
    @(negedge clk);
    do_reset();

    // table walk: R1 R2 R3 R10 R6
    for (int i = 0; i < 20; i++) begin
      logic [5:0] t;
      t = VEC[i];
      cyc(t[5], t[4], t[3:2], t[1:0], 0, 0, "R1");
    end
    finish_window("R2");

    // R3: all received bits erased, mismatching values
    for (int i = 0; i < 8; i++) cyc(1, 1, 2'b00, 2'b11, 0, 0, "R3");
    for (int i = 0; i < 8; i++) cyc(1, 0, 2'b11, 2'b11, 0, 0, "R3");
    chk(st_tdata == 0, "R3", int'(st_tdata), 0);

    // R9: partial window with errors then reset
    for (int i = 0; i < 6; i++) cyc(1, 0, 2'b11, 2'b00, 0, 0, "R9");
    do_reset();
    for (int i = 0; i < 8; i++) cyc(1, i[0], 2'b11, 2'b00, 0, 0, "R9");

    // R6: hold under back-pressure and overwrite
    cyc(0, 0, 0, 0, 1, 2, "R4");
    finish_window("R5");
    st_tready = 0;
    cyc(1, 1, 2'b00, 2'b00, 0, 0, "R6");
    cyc(1, 0, 2'b11, 2'b00, 0, 0, "R6");
    held = st_tdata;
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 0, 0, 0, 0, "R6");
      chk(st_tvalid && st_tdata == held, "R6", int'(st_tdata), int'(held));
    end
    cyc(1, 1, 2'b10, 2'b00, 0, 0, "R6");
    cyc(1, 1, 2'b01, 2'b00, 0, 0, "R6");
    st_tready = 1;
    cyc(0, 0, 0, 0, 0, 0, "R6");
    chk(!st_tvalid, "R6", int'(st_tvalid), 0);

    // R5: length written mid-window applies to the next window
    cyc(1, 1, 2'b11, 2'b00, 0, 0, "R5");
    cyc(0, 0, 0, 0, 1, 5, "R5");
    cyc(1, 0, 2'b10, 2'b00, 0, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(1, i[1], 2'b01, 2'b00, 0, 0, "R5");
    chk(m_cnt == 4 && !st_tvalid, "R5", int'(st_tvalid), 0);
    cyc(1, 1, 2'b11, 2'b00, 0, 0, "R5");

    // R4: zero length means one symbol per window
    cyc(0, 0, 0, 0, 1, 0, "R4");
    finish_window("R4");
    cyc(1, 1, 2'b00, 2'b00, 0, 0, "R4");
    cyc(1, 0, 2'b11, 2'b00, 0, 0, "R4");
    cyc(1, 1, 2'b10, 2'b01, 0, 0, "R4");

    // R7: saturation
    cyc(0, 0, 0, 0, 1, 40000, "R7");
    finish_window("R7");
    for (int i = 0; i < 40000; i++) cyc(1, 0, 2'b11, 2'b00, 0, 0, "R7");
    chk(st_tdata == 16'hFFFF, "R7", int'(st_tdata), 65535);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule